// File: doc/BRIEF.md
# Three-Wire Serial Byte Engine

This block is the bit-level master for a device attached by three wires: an active-low device reset line, a serial clock line and one bidirectional data line. A requester hands it one command at a time. The command can be a reset handshake, a byte write or a byte read. The engine then produces the line waveform for that command. Each waveform step lasts a set number of system clock cycles, given by parameters. For simulation these parameters can be made very short.

A command is offered with `cmd_valid`, `cmd_op` and `cmd_wdata`. It is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. This is the only back-pressure in the block. `cmd_ready` is low for the whole time a command is in progress, and the requester must hold its command until it is taken. A `cmd_valid` that arrives while the engine is busy has no effect.

Completion is a one-cycle `rsp_done` strobe, and it cannot be stalled. After a read, `rsp_rdata` holds the received byte and keeps it until the next read completes. The data line is handled through `dq_out` and `dq_oe`, with the pad value returned on `dq_in`. Bytes travel least significant bit first. Which commands are issued, and in what order, is decided outside this block, as is the meaning of the data.

Top module: `twire_byte_engine`

## Requirements
- R1: After system reset, `line_rst_n`=1, `line_clk`=1, `dq_oe`=0, `busy`=0 and `cmd_ready`=1.
- R2: A reset command (`cmd_op`=2'b01) drives `line_rst_n` low for exactly RST_LOW_CYC cycles, and at no other time.
- R3: When a reset command releases `line_rst_n`, the engine holds `line_clk`=0, `dq_oe`=1 and `dq_out`=0 for SETTLE_CYC cycles, then completes.
- R4: A write command (`cmd_op`=2'b10) first spends one cycle with `dq_oe`=1 and `dq_out`=1, before bit 0 appears on the line.
- R5: A write sends the 8 bits of `cmd_wdata` LSB first. Each bit goes through three phases of PHASE_CYC cycles each: the bit is set up with `line_clk` low, then `line_clk` is high, then `line_clk` is low. `dq_out` is stable while `line_clk` is high.
- R6: A read command (`cmd_op`=2'b11) keeps `dq_oe`=0 throughout. For each of 8 bits, `line_clk` is low for PHASE_CYC cycles, `dq_in` is sampled at the end of that low phase, and then `line_clk` is high for PHASE_CYC cycles. Received bits fill the byte LSB first.
- R7: `cmd_ready` equals the inverse of `busy`. A command is taken only when `cmd_valid` and `cmd_ready` are both high. `busy` is high from the cycle after the command is taken until completion. A `cmd_valid` raised while `busy` is high starts nothing.
- R8: Every command ends with `rsp_done` high for exactly one cycle, and that cycle is the first cycle in which `busy` is low again.
- R9: `cmd_op`=2'b00 is a no-operation code. It is never taken, and it changes neither `busy`, `rsp_done` nor the line outputs.
- R10: `rsp_rdata` shows the byte received by the latest completed read, from its `rsp_done` cycle onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 2 | 00 none, 01 reset handshake, 10 write byte, 11 read byte |
| cmd_wdata | input | DATA_W | Byte to write |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DATA_W | Last byte read |
| busy | output | 1 | Command in progress |
| line_rst_n | output | 1 | Device reset line, active low |
| line_clk | output | 1 | Serial clock line |
| dq_out | output | 1 | Data line value when driven |
| dq_oe | output | 1 | Data line output enable |
| dq_in | input | 1 | Data line value from the pad |

## Verification
The hardest case to reach is a new request arriving in the middle of a transfer. The bench raises `cmd_valid` with a read code part way through a write. It then checks that the write bits still come out intact, that only one completion strobe appears, and that the engine goes idle afterwards. The read sampling point is checked with a device model in the bench. The model moves to its next bit only on a rising `line_clk`, so a byte is correct only if the engine samples at the end of each low phase.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } twb_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RLOW,
    S_RSETTLE,
    S_WPREP,
    S_WSETUP,
    S_WHIGH,
    S_WLOW,
    S_RDLOW,
    S_RDHIGH
  } twb_state_e;
endpackage

// File: rtl/twb_phase_timer.sv
module twb_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) == '0) |-> cnt_q == '0); // R5
endmodule

// File: rtl/twb_shifter.sv
module twb_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              in_bit,
  output logic [DATA_W-1:0] q,
  output logic              last,
  output logic              full
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      cnt_q <= '0;
    end else if (load) begin
      q     <= load_val;
      cnt_q <= '0;
    end else if (shift) begin
      q     <= {in_bit, q[DATA_W-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == CW'(DATA_W - 1));
  assign full = (cnt_q == CW'(DATA_W));

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DATA_W)); // R5
endmodule

// File: rtl/twire_byte_engine.sv
module twire_byte_engine
  import twb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PHASE_CYC   = 1000,
  parameter int RST_LOW_CYC = 100000,
  parameter int SETTLE_CYC  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              line_rst_n,
  output logic              line_clk,
  output logic              dq_out,
  output logic              dq_oe,
  input  logic              dq_in
);
  localparam int MAX_A = (PHASE_CYC > SETTLE_CYC) ? PHASE_CYC : SETTLE_CYC;
  localparam int MAX_CYC = (MAX_A > RST_LOW_CYC) ? MAX_A : RST_LOW_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  twb_state_e state_q, state_d;
  twb_op_e    op_q;
  logic       busy_q, done_q, clk_q, oe_q;
  logic [DATA_W-1:0] rdata_q;

  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_in, sh_last, sh_full;
  logic [DATA_W-1:0] sh_q, sh_val;
  logic             accept;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready && (twb_op_e'(cmd_op) != OP_NONE);

  twb_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp)
  );

  twb_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .in_bit(sh_in), .q(sh_q), .last(sh_last), .full(sh_full)
  );

  always_comb begin
    state_d  = state_q;
    sh_load  = 1'b0;
    sh_val   = '0;
    sh_shift = 1'b0;
    sh_in    = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        unique case (twb_op_e'(cmd_op))
          OP_RESET: state_d = S_RLOW;
          OP_WRITE: begin state_d = S_WPREP; sh_load = 1'b1; sh_val = cmd_wdata; end
          OP_READ:  begin state_d = S_RDLOW; sh_load = 1'b1; end
          default:  state_d = S_IDLE;
        endcase
      end
      S_RLOW:    if (tmr_exp) state_d = S_RSETTLE;
      S_RSETTLE: if (tmr_exp) state_d = S_IDLE;
      S_WPREP:   state_d = S_WSETUP;
      S_WSETUP:  if (tmr_exp) state_d = S_WHIGH;
      S_WHIGH:   if (tmr_exp) state_d = S_WLOW;
      S_WLOW: if (tmr_exp) begin
        sh_shift = 1'b1;
        state_d  = sh_last ? S_IDLE : S_WSETUP;
      end
      S_RDLOW: if (tmr_exp) begin
        sh_shift = 1'b1;
        sh_in    = dq_in;
        state_d  = S_RDHIGH;
      end
      S_RDHIGH: if (tmr_exp) state_d = sh_full ? S_IDLE : S_RDLOW;
      default: state_d = S_IDLE;
    endcase
  end

  // Every phase entry is a state change, so the timer restarts on it.
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      S_RLOW:    tmr_val = CNT_W'(RST_LOW_CYC - 1);
      S_RSETTLE: tmr_val = CNT_W'(SETTLE_CYC - 1);
      default:   tmr_val = CNT_W'(PHASE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_NONE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      clk_q   <= 1'b1;
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= twb_op_e'(cmd_op);
      end
      if (state_q != S_IDLE && state_d == S_IDLE) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (op_q == OP_READ) rdata_q <= sh_q;
      end
      unique case (state_d)
        S_RSETTLE, S_WPREP, S_WSETUP, S_WLOW: begin clk_q <= 1'b0; oe_q <= 1'b1; end
        S_WHIGH:  begin clk_q <= 1'b1; oe_q <= 1'b1; end
        S_RDLOW:  begin clk_q <= 1'b0; oe_q <= 1'b0; end
        S_RDHIGH: begin clk_q <= 1'b1; oe_q <= 1'b0; end
        default: ;
      endcase
    end
  end

  assign busy       = busy_q;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign line_rst_n = (state_q != S_RLOW);
  assign line_clk   = clk_q;
  assign dq_oe      = oe_q;
  assign dq_out     = (state_q == S_WPREP) ? 1'b1 :
                      (state_q == S_WSETUP || state_q == S_WHIGH || state_q == S_WLOW) ? sh_q[0] :
                      1'b0;

  AST_RST_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !line_rst_n |-> busy); // R2
  AST_SETTLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_rst_n) && busy) |-> (!line_clk && dq_oe && !dq_out)); // R3
  AST_WR_DQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_clk && $past(line_clk) && dq_oe) |-> $stable(dq_out)); // R5
  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_READ) |-> !dq_oe); // R6
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid)); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!busy && $past(busy))); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8
endmodule

// File: tb/sim_twire_byte_engine.sv
module sim_twire_byte_engine;
  localparam int DW = 8;
  localparam int PH = 4;
  localparam int RL = 20;
  localparam int ST = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_done, busy, line_rst_n, line_clk, dq_out, dq_oe, dq_in;
  logic [DW-1:0] rsp_rdata;

  always #5 clk = ~clk;

  twire_byte_engine #(.DATA_W(DW), .PHASE_CYC(PH), .RST_LOW_CYC(RL), .SETTLE_CYC(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .busy(busy), .line_rst_n(line_rst_n), .line_clk(line_clk), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // Device model: presents the next bit, advancing on each rising line_clk.
  logic [DW-1:0] dev_byte = '0;
  int dev_idx = 0;
  always @(posedge line_clk) dev_idx <= dev_idx + 1;
  assign dq_in = (dev_idx < DW) ? dev_byte[dev_idx] : 1'b0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Observations gathered over one command.
  int o_rlow, o_settle, o_clkhi, o_bits, o_dones, o_oe_in_read, o_prep_ok, o_dq_unstable;
  int o_hi_bad;
  logic [DW-1:0] o_wbyte;

  task automatic run_cmd(input logic [1:0] op, input logic [DW-1:0] wd,
                         input logic [DW-1:0] dbyte, input bit inject);
    logic pclk, pdq;
    int hi_run;
    dev_byte = dbyte;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd;
    dev_idx = 0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    o_rlow = 0; o_settle = 0; o_clkhi = 0; o_bits = 0; o_dones = 0;
    o_oe_in_read = 0; o_dq_unstable = 0; o_wbyte = '0; o_hi_bad = 0; hi_run = 0;
    o_prep_ok = (dq_oe === 1'b1 && dq_out === 1'b1) ? 1 : 0;
    pclk = line_clk; pdq = dq_out;
    for (int c = 0; c < 2000; c++) begin
      if (inject && c == 30) begin cmd_valid = 1'b1; cmd_op = 2'b11; end
      if (inject && c == 40) begin cmd_valid = 1'b0; cmd_op = 2'b00; end
      if (rsp_done) begin o_dones++; break; end
      if (!line_rst_n) o_rlow++;
      if (op == 2'b01 && line_rst_n && busy && o_rlow > 0) o_settle++;
      if (op == 2'b11 && dq_oe) o_oe_in_read++;
      if (line_clk) begin
        o_clkhi++; hi_run++;
        if (pclk && dq_out !== pdq) o_dq_unstable++;
      end else begin
        if (pclk && hi_run != PH && op != 2'b01) o_hi_bad++;
        hi_run = 0;
      end
      if (line_clk && !pclk && op == 2'b10) begin
        o_wbyte = {dq_out, o_wbyte[DW-1:1]};
        o_bits++;
      end
      pclk = line_clk; pdq = dq_out;
      @(negedge clk);
    end
    // Count any further strobe shortly after completion.
    cmd_valid = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (rsp_done) o_dones++;
    end
  endtask

  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {2'b01, 8'h00, 8'h00},
    {2'b10, 8'hA5, 8'h00},
    {2'b11, 8'h00, 8'h3C},
    {2'b10, 8'h01, 8'h00},
    {2'b11, 8'h00, 8'h80},
    {2'b10, 8'hFF, 8'h00},
    {2'b11, 8'h00, 8'hD2},
    {2'b10, 8'h00, 8'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(line_rst_n === 1'b1, "R1 rst line", line_rst_n, 1);
    chk(line_clk === 1'b1, "R1 clk line", line_clk, 1);
    chk(dq_oe === 1'b0, "R1 dq released", dq_oe, 0);
    chk(busy === 1'b0 && cmd_ready === 1'b1, "R1 idle", {busy, cmd_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      logic [DW-1:0] wd, db;
      op = VEC[v][17:16]; wd = VEC[v][15:8]; db = VEC[v][7:0];
      run_cmd(op, wd, db, 1'b0);
      chk(o_dones == 1, "R8 single done", o_dones, 1);
      chk(busy === 1'b0 && cmd_ready === 1'b1, "R7 idle after", busy, 0);
      if (op == 2'b01) begin
        chk(o_rlow == RL, "R2 reset low cycles", o_rlow, RL);
        chk(o_settle == ST, "R3 settle cycles", o_settle, ST);
        chk(line_clk === 1'b0 && dq_oe === 1'b1 && dq_out === 1'b0, "R3 levels after reset",
            {line_clk, dq_oe, dq_out}, 3'b010);
      end else if (op == 2'b10) begin
        chk(o_rlow == 0, "R2 no reset in write", o_rlow, 0);
        chk(o_prep_ok == 1, "R4 dq high before bit0", o_prep_ok, 1);
        chk(o_bits == DW, "R5 bit count", o_bits, DW);
        chk(o_wbyte == wd, "R5 write byte LSB first", o_wbyte, wd);
        chk(o_clkhi == DW * PH && o_hi_bad == 0, "R5 clk high phases", o_clkhi, DW * PH);
        chk(o_dq_unstable == 0, "R5 dq stable while clk high", o_dq_unstable, 0);
      end else begin
        chk(o_oe_in_read == 0, "R6 dq released in read", o_oe_in_read, 0);
        chk(o_clkhi == DW * PH && o_hi_bad == 0, "R6 clk high phases", o_clkhi, DW * PH);
        chk(rsp_rdata == db, "R6 R10 read byte", rsp_rdata, db);
      end
    end

    // R7: read request raised during a write is not taken.
    run_cmd(2'b10, 8'h96, 8'h00, 1'b1);
    chk(o_wbyte == 8'h96, "R7 write intact under request", o_wbyte, 8'h96);
    chk(o_dones == 1, "R7 only one completion", o_dones, 1);
    chk(busy === 1'b0, "R7 no queued command", busy, 0);
    chk(rsp_rdata == 8'hD2, "R10 rdata kept by write", rsp_rdata, 8'hD2);

    // R9: no-operation code is never taken.
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b00;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (busy || rsp_done || !line_rst_n || line_clk) seen++;
      end
      cmd_valid = 1'b0;
      chk(seen == 0, "R9 no-op ignored", seen, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule